// File: doc/BRIEF.md
# Four-Way Pairwise Replacement Selector

This block holds the replacement-order record for every set of a four-way set-associative cache and names the way to evict on a miss. Each set keeps six bits, one for each unordered pair of ways. Each bit says which member of its pair was touched more recently. The cache controller presents a set index and reads the victim way and a fill-permission flag combinationally. After a hit in a way, or a fill into a way, the controller pulses an update strobe for that way. A purge clears every set at once. A software write port can force one set's record, and the only legal value to write is zero.

Pair bits are laid out as bit 0 = ways (0,1), bit 1 = (0,2), bit 2 = (0,3), bit 3 = (1,2), bit 4 = (1,3), bit 5 = (2,3). For a pair (i, j) with i < j, a 1 means way j is the more recent and a 0 means way i is. A cleared record therefore ranks the ways, from oldest to newest, as 3, 2, 1, 0.

Two replacement-inhibit controls exist, one for instruction fetches and one for data reads. When the control for the current access type is set, a miss must not allocate a line, and the missed line (16 bytes) goes straight to the requester. A two-way mode restricts eviction to ways 2 and 3.

Top module: `plru4_repl_sel`

## Requirements
- R1: After reset, every set's record is zero and the victim of every set is way 3.
- R2: An applied update to way w leaves w the most recent way of the set: w is not the victim in four-way mode until another update or write changes that set.
- R3: Starting from a zero record, four successive fills, each into the victim shown at that time, show the victims 3, 2, 1, 0 in that order.
- R4: In four-way mode, the victim is the way ranked older than all three other ways under the pair encoding stated above.
- R5: `fill_ok` is 0 when `acc_inst`=0 and `inh_data`=1, or when `acc_inst`=1 and `inh_inst`=1; otherwise it is 1.
- R6: An update with `upd_fill`=1 while `fill_ok`=0 leaves the set's record unchanged.
- R7: An update with `upd_fill`=0 (a hit) is applied whatever the inhibit controls are.
- R8: With `two_way`=1, the victim is way 3 when pair bit (2,3) is 0 and way 2 when it is 1. Hits in ways 0 and 1 still update the record.
- R9: A software write replaces the addressed set's record. When it addresses the same set as an update in the same cycle, the write wins.
- R10: A purge zeroes every set on the next edge and takes priority over both a same-cycle update and a same-cycle software write.
- R11: Updates and writes change only the set they address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_idx | input | SET_W | Set addressed by lookup and update |
| acc_inst | input | 1 | Access type: 1 instruction fetch, 0 data |
| inh_inst | input | 1 | Inhibit allocation on instruction misses |
| inh_data | input | 1 | Inhibit allocation on data-read misses |
| two_way | input | 1 | Restrict victims to ways 2 and 3 |
| upd_en | input | 1 | Update strobe for way `upd_way` |
| upd_fill | input | 1 | 1: the update is a fill after a miss, 0: a hit |
| upd_way | input | 2 | Way touched by the update |
| purge | input | 1 | Clear all records |
| sw_wr_en | input | 1 | Software record write strobe |
| sw_wr_set | input | SET_W | Set targeted by the software write |
| sw_wr_data | input | 6 | Record value to write (legal value: zero) |
| victim_way | output | 2 | Way to replace in set `set_idx` |
| fill_ok | output | 1 | Allocation allowed for the current access type |

## Verification
The bench keeps its own recency ranking per set, stored as ages rather than pair bits, and compares the victim against it. The patterns are the ordered fill walk from a cleared record, hits in every way of four small sets, inhibited fills of each access type, and two-way mode mixed with hits in the lower ways. This set of patterns separates pair-bit mapping errors, an update that ignores the inhibit controls, a wrong two-way tie bit, and leakage across sets. Directed same-cycle collisions of purge, software write and update show the priority order. A long pseudo-random mix then checks the victim and the fill flag on every cycle.

// File: rtl/plru_pkg.sv
package plru_pkg;
    localparam int WAYS   = 4;
    localparam int PAIRS  = WAYS * (WAYS - 1) / 2;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [PAIRS-1:0] plru_rec_t;
    typedef logic [WAY_W-1:0] way_t;

    // bit position of pair (lo, hi), lo < hi, enumerated lexicographically
    function automatic int pair_pos(input int lo, input int hi);
        int k;
        k = 0;
        for (int a = 0; a < WAYS; a++) begin
            for (int b = a + 1; b < WAYS; b++) begin
                if (a == lo && b == hi) return k;
                k++;
            end
        end
        return 0;
    endfunction
endpackage

// File: rtl/plru_rec_next.sv
module plru_rec_next
    import plru_pkg::*;
(
    input  plru_rec_t cur_rec,
    input  way_t      touch_way,
    output plru_rec_t nxt_rec
);
    always_comb begin
        nxt_rec = cur_rec;
        for (int a = 0; a < WAYS; a++) begin
            for (int b = a + 1; b < WAYS; b++) begin
                if (int'(touch_way) == a) nxt_rec[pair_pos(a, b)] = 1'b0;
                if (int'(touch_way) == b) nxt_rec[pair_pos(a, b)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
    import plru_pkg::*;
(
    input  plru_rec_t rec,
    input  logic      two_way,
    output way_t      victim
);
    logic [WAYS-1:0] oldest;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            oldest[w] = 1'b1;
            for (int v = 0; v < WAYS; v++) begin
                if (v > w && !rec[pair_pos(w, v)]) oldest[w] = 1'b0;
                if (v < w &&  rec[pair_pos(v, w)]) oldest[w] = 1'b0;
            end
        end
    end

    always_comb begin
        victim = way_t'(WAYS - 1);
        if (two_way) begin
            victim = rec[pair_pos(2, 3)] ? way_t'(2) : way_t'(3);
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (oldest[w]) victim = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/plru_rec_store.sv
module plru_rec_store
    import plru_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             purge,
    input  logic             upd_go,
    input  logic [SET_W-1:0] upd_set,
    input  plru_rec_t        upd_rec,
    input  logic             sw_en,
    input  logic [SET_W-1:0] sw_set,
    input  plru_rec_t        sw_rec,
    input  logic [SET_W-1:0] rd_set,
    output plru_rec_t        rd_rec
);
    plru_rec_t rec_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rec_q[s] <= '0;
        end else if (purge) begin
            for (int s = 0; s < SETS; s++) rec_q[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (sw_en && int'(sw_set) == s)
                    rec_q[s] <= sw_rec;
                else if (upd_go && int'(upd_set) == s)
                    rec_q[s] <= upd_rec;
            end
        end
    end

    assign rd_rec = rec_q[rd_set];
endmodule

// File: rtl/plru4_repl_sel.sv
module plru4_repl_sel
    import plru_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             acc_inst,
    input  logic             inh_inst,
    input  logic             inh_data,
    input  logic             two_way,
    input  logic             upd_en,
    input  logic             upd_fill,
    input  logic [1:0]       upd_way,
    input  logic             purge,
    input  logic             sw_wr_en,
    input  logic [SET_W-1:0] sw_wr_set,
    input  logic [5:0]       sw_wr_data,
    output logic [1:0]       victim_way,
    output logic             fill_ok
);
    plru_rec_t cur_rec;
    plru_rec_t nxt_rec;
    logic      upd_go;

    assign fill_ok = acc_inst ? !inh_inst : !inh_data;
    assign upd_go  = upd_en && (!upd_fill || fill_ok);

    plru_rec_store #(.SETS(SETS), .SET_W(SET_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .purge   (purge),
        .upd_go  (upd_go),
        .upd_set (set_idx),
        .upd_rec (nxt_rec),
        .sw_en   (sw_wr_en),
        .sw_set  (sw_wr_set),
        .sw_rec  (sw_wr_data),
        .rd_set  (set_idx),
        .rd_rec  (cur_rec)
    );

    plru_rec_next u_next (
        .cur_rec   (cur_rec),
        .touch_way (upd_way),
        .nxt_rec   (nxt_rec)
    );

    plru_victim_pick u_pick (
        .rec     (cur_rec),
        .two_way (two_way),
        .victim  (victim_way)
    );
endmodule

// File: rtl/plru4_repl_sel_chk.sv
module plru4_repl_sel_chk #(
    parameter int SET_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SET_W-1:0] set_idx,
    input logic             acc_inst,
    input logic             inh_inst,
    input logic             inh_data,
    input logic             two_way,
    input logic             upd_en,
    input logic             upd_fill,
    input logic [1:0]       upd_way,
    input logic             purge,
    input logic             sw_wr_en,
    input logic [SET_W-1:0] sw_wr_set,
    input logic [1:0]       victim_way,
    input logic             fill_ok
);
    AST_DATA_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_inst && inh_data) |-> !fill_ok); // R5
    AST_INST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_inst && inh_inst) |-> !fill_ok); // R5
    AST_TWO_WAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        two_way |-> victim_way[1]); // R8
    AST_PURGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (victim_way == 2'd3)); // R10
    AST_TOUCHED_NOT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !purge && !upd_fill && !(sw_wr_en && sw_wr_set == set_idx))
        |=> (!$stable(set_idx) || two_way || (purge && 1'b0) ||
             (sw_wr_en && sw_wr_set == set_idx && 1'b0) ||
             victim_way != $past(upd_way))); // R2
endmodule

bind plru4_repl_sel plru4_repl_sel_chk #(.SET_W(SET_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .acc_inst   (acc_inst),
    .inh_inst   (inh_inst),
    .inh_data   (inh_data),
    .two_way    (two_way),
    .upd_en     (upd_en),
    .upd_fill   (upd_fill),
    .upd_way    (upd_way),
    .purge      (purge),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_set  (sw_wr_set),
    .victim_way (victim_way),
    .fill_ok    (fill_ok)
);

// File: tb/tb_plru4_repl_sel.sv
module tb_plru4_repl_sel;
    localparam int SETS  = 64;
    localparam int SET_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SET_W-1:0] set_idx = '0;
    logic             acc_inst = 1'b0, inh_inst = 1'b0, inh_data = 1'b0;
    logic             two_way = 1'b0, upd_en = 1'b0, upd_fill = 1'b0;
    logic [1:0]       upd_way = '0;
    logic             purge = 1'b0, sw_wr_en = 1'b0;
    logic [SET_W-1:0] sw_wr_set = '0;
    logic [5:0]       sw_wr_data = '0;
    logic [1:0]       victim_way;
    logic             fill_ok;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int age [SETS][4];

    always #10 clk = ~clk;

    plru4_repl_sel #(.SETS(SETS), .SET_W(SET_W)) dut (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_inst(acc_inst),
        .inh_inst(inh_inst), .inh_data(inh_data), .two_way(two_way),
        .upd_en(upd_en), .upd_fill(upd_fill), .upd_way(upd_way),
        .purge(purge), .sw_wr_en(sw_wr_en), .sw_wr_set(sw_wr_set),
        .sw_wr_data(sw_wr_data), .victim_way(victim_way), .fill_ok(fill_ok)
    );

    function automatic void clear_set(int s);
        for (int w = 0; w < 4; w++) age[s][w] = w;
    endfunction

    function automatic void touch(int s, int w);
        int a;
        a = age[s][w];
        for (int v = 0; v < 4; v++) if (age[s][v] < a) age[s][v] = age[s][v] + 1;
        age[s][w] = 0;
    endfunction

    function automatic int exp_victim(int s, bit tw);
        if (tw) return (age[s][2] > age[s][3]) ? 2 : 3;
        for (int w = 0; w < 4; w++) if (age[s][w] == 3) return w;
        return 3;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive after negedge, check before posedge, then model the edge
    task automatic cycle(string req);
        bit ok_exp;
        #1;
        ok_exp = acc_inst ? !inh_inst : !inh_data;
        check(req, int'(victim_way), exp_victim(int'(set_idx), two_way));
        check("R5", int'(fill_ok), int'(ok_exp));
        @(posedge clk);
        if (purge) begin
            for (int s = 0; s < SETS; s++) clear_set(s);
        end else begin
            if (sw_wr_en) clear_set(int'(sw_wr_set));
            if (upd_en && (!upd_fill || ok_exp) &&
                !(sw_wr_en && sw_wr_set == set_idx))
                touch(int'(set_idx), int'(upd_way));
        end
        @(negedge clk);
        upd_en = 0; purge = 0; sw_wr_en = 0;
    endtask

    task automatic do_upd(int s, int w, bit fill, string req);
        set_idx = SET_W'(s); upd_way = 2'(w); upd_fill = fill; upd_en = 1;
        cycle(req);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) clear_set(s);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state on all sets
        for (int s = 0; s < SETS; s++) begin
            set_idx = SET_W'(s); #1;
            check("R1", int'(victim_way), 3);
        end
        // R3: fill walk from zero, each fill into the shown victim
        set_idx = 6'd5;
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R3", int'(victim_way), 3 - k);
            do_upd(5, int'(victim_way), 1'b1, "R3");
        end
        // R2/R4: hit every way in four sets
        for (int s = 8; s < 12; s++)
            for (int w = 0; w < 4; w++) begin
                do_upd(s, (w * 3 + s) % 4, 1'b0, "R4");
                #1; check("R2", int'(victim_way == 2'((w * 3 + s) % 4)), 0);
            end
        // R11: set 7 untouched by all the above
        set_idx = 6'd7; #1; check("R11", int'(victim_way), 3);
        // R6: inhibited data fill leaves state alone
        inh_data = 1; acc_inst = 0;
        do_upd(20, 3, 1'b1, "R6");
        set_idx = 6'd20; #1; check("R6", int'(victim_way), 3);
        // R7: hit applied despite inhibit
        do_upd(20, 3, 1'b0, "R7");
        set_idx = 6'd20; #1; check("R7", int'(victim_way), 2);
        inh_data = 0; inh_inst = 1; acc_inst = 1;
        do_upd(21, 3, 1'b1, "R6");
        set_idx = 6'd21; #1; check("R6", int'(victim_way), 3);
        inh_inst = 0; acc_inst = 0;
        // R8: two-way mode, hits in low ways still update
        two_way = 1;
        do_upd(22, 0, 1'b0, "R8");
        do_upd(22, 3, 1'b0, "R8");
        set_idx = 6'd22; #1; check("R8", int'(victim_way), 2);
        do_upd(22, 2, 1'b0, "R8");
        set_idx = 6'd22; #1; check("R8", int'(victim_way), 3);
        two_way = 0;
        #1; check("R8", int'(victim_way), 1);
        // R9: software write beats same-set update
        sw_wr_en = 1; sw_wr_set = 6'd22; sw_wr_data = '0;
        do_upd(22, 3, 1'b0, "R9");
        set_idx = 6'd22; #1; check("R9", int'(victim_way), 3);
        // R10: purge beats write and update
        do_upd(9, 2, 1'b0, "R10");
        purge = 1; sw_wr_en = 1; sw_wr_set = 6'd9;
        do_upd(9, 3, 1'b0, "R10");
        for (int s = 8; s < 12; s++) begin
            set_idx = SET_W'(s); #1; check("R10", int'(victim_way), 3);
        end
        // pseudo-random sweep over four sets
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                acc_inst = lf[0]; inh_inst = lf[1] & lf[2]; inh_data = lf[3] & lf[4];
                two_way  = lf[5] & lf[6] & lf[7];
                sw_wr_en = (lf[11:8] == 4'hF); sw_wr_set = SET_W'(lf[13:12]);
                sw_wr_data = '0;
                purge = (lf[15:8] == 8'h5A);
                upd_en = lf[14] | lf[9]; upd_fill = lf[10];
                set_idx = SET_W'({lf[2], lf[12]});
                upd_way = (upd_fill && lf[5]) ? 2'(exp_victim(int'(set_idx), two_way))
                                              : lf[7:6];
                cycle("R4");
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule